// File: doc/BRIEF.md
# Ten-State Johnson Counter with One-Hot Decode

This block divides a slow count clock by ten. The count is held in a five-bit twisted-ring (Johnson) register that steps through ten legal patterns. Ten one-hot outputs show the current count, and a carry output completes one high/low cycle every ten counts. The block runs on a free-running system clock. The count-clock and inhibit pins are treated as asynchronous. Each one passes through a two-flop synchroniser, and the block then detects its edges.

The count steps on a rising count-clock edge while inhibit is low. It also steps on a falling inhibit edge while the count clock is high. While inhibit is high, count-clock edges are ignored. The clear input forces count zero at once, and the block leaves clear in step with the system clock. A ring pattern outside the legal set is replaced by count zero at the next step.

Decades cascade by feeding `carry_o` of one stage into `cnt_clk_i` of the next. Every pin is a plain control or status level. The block has no data stream, so it has no valid/ready handshake and never applies back-pressure.

Top module: `johnson_decade_counter`

## Requirements
- R1: The ring visits these patterns in order, written state[4:0]: 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. Pattern k is count k, and after count 9 the ring returns to count 0.
- R2: A rising edge of `cnt_clk_i` while `inhibit_i` is low advances the count by exactly one. The new count shows at the outputs within four system clocks. A falling edge of `cnt_clk_i` alone never advances the count.
- R3: While `inhibit_i` is high, edges of `cnt_clk_i` leave the count unchanged. A falling edge of inhibit while the count clock is low also leaves the count unchanged.
- R4: A falling edge of `inhibit_i` while `cnt_clk_i` is high advances the count by exactly one.
- R5: While `clr_i` is high, the count is zero with no wait for a system clock, whatever the other inputs do. Releasing clear while `cnt_clk_i` is already high does not advance the count.
- R6: For a legal ring pattern, exactly one bit of `dec_o` is high: bit k for count k. Each bit is decoded from two adjacent ring bits only.
- R7: For a legal ring pattern, `carry_o` is high for counts 0 to 4 and low for counts 5 to 9. It therefore rises on the step from count 9 to count 0.
- R8: From any of the 22 illegal five-bit patterns, the next advance puts the ring at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| clr_i | input | 1 | Active-high clear; asserts asynchronously, released on the system clock |
| cnt_clk_i | input | 1 | Asynchronous count clock; rising edges step the count |
| inhibit_i | input | 1 | Asynchronous inhibit; high blocks count-clock edges |
| dec_o | output | 10 | One-hot decoded count, bit k high at count k |
| carry_o | output | 1 | Divide-by-ten carry, high for counts 0 to 4 |

## Verification
The checker assumes that `cnt_clk_i` and `inhibit_i` each hold a level for at least three system clocks, so that every edge survives the synchroniser as a single step. It also assumes that clear stays high long enough for the synchronisers to fill before the ring leaves reset. The bench keeps every input level for five system clocks and holds clear for several clocks.

The one-hot and carry properties apply only while the ring pattern is legal. Illegal patterns are placed into the ring directly, and the properties tolerate them until the recovery step.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  // Default ring width: a Johnson ring of W bits has 2*W legal states.
  localparam int RING_W_DEF = 5;
  localparam int SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/dcnt_sync.sv
// Plain flop chain synchroniser for one asynchronous level.
module dcnt_sync #(
  parameter int STAGES = dcnt_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcnt_edge.sv
// Turns the synchronised count clock and inhibit into a one-cycle advance.
module dcnt_edge (
  input  logic clk_i,
  input  logic cclk_s_i,
  input  logic inh_s_i,
  output logic adv_o
);
  logic cclk_prev_q;
  logic inh_prev_q;

  // Left without reset so that they already track the pins when clear lifts.
  always_ff @(posedge clk_i) begin
    cclk_prev_q <= cclk_s_i;
    inh_prev_q  <= inh_s_i;
  end

  logic clk_rise;
  logic inh_fall;

  assign clk_rise = cclk_s_i & ~cclk_prev_q;
  assign inh_fall = inh_prev_q & ~inh_s_i;
  assign adv_o    = (clk_rise & ~inh_s_i) | (inh_fall & cclk_s_i);
endmodule

// File: rtl/dcnt_ring.sv
// Twisted-ring state with lock-out recovery.
module dcnt_ring #(
  parameter int RING_W = dcnt_pkg::RING_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [RING_W-1:0] state_o,
  output logic              legal_o
);
  logic [RING_W-1:0] state_q;
  logic [RING_W-1:0] state_nxt;

  // A legal Johnson pattern has at most one change between neighbouring bits.
  assign legal_o   = ($countones(state_q[RING_W-1:1] ^ state_q[RING_W-2:0]) <= 1);
  assign state_nxt = legal_o ? {state_q[RING_W-2:0], ~state_q[RING_W-1]}
                             : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= '0;
    else if (adv_i) state_q <= state_nxt;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dcnt_decode.sv
// Two-input decode of each count from neighbouring ring bits.
module dcnt_decode #(
  parameter int RING_W = dcnt_pkg::RING_W_DEF,
  localparam int COUNT_N = 2 * RING_W
) (
  input  logic [RING_W-1:0]  state_i,
  output logic [COUNT_N-1:0] dec_o,
  output logic               carry_o
);
  for (genvar k = 0; k < COUNT_N; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec_o[k] = ~state_i[RING_W-1] & ~state_i[0];
    end else if (k < RING_W) begin : g_fill
      assign dec_o[k] = state_i[k-1] & ~state_i[k];
    end else if (k == RING_W) begin : g_full
      assign dec_o[k] = state_i[RING_W-1] & state_i[0];
    end else begin : g_drain
      assign dec_o[k] = ~state_i[k-RING_W-1] & state_i[k-RING_W];
    end
  end

  assign carry_o = ~state_i[RING_W-1];
endmodule

// File: rtl/johnson_decade_counter.sv
module johnson_decade_counter #(
  parameter int RING_W      = dcnt_pkg::RING_W_DEF,
  parameter int SYNC_STAGES = dcnt_pkg::SYNC_STAGES_DEF,
  localparam int COUNT_N    = 2 * RING_W
) (
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic               cnt_clk_i,
  input  logic               inhibit_i,
  output logic [COUNT_N-1:0] dec_o,
  output logic               carry_o
);
  // Clear: asserted at once, released on the system clock.
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i) rst_pipe_q <= '0;
    else       rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic cclk_s;
  logic inh_s;
  logic adv;
  logic legal;
  logic [RING_W-1:0] state;

  dcnt_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk_i (clk_i), .d_i (cnt_clk_i), .q_o (cclk_s)
  );
  dcnt_sync #(.STAGES(SYNC_STAGES)) u_sync_inh (
    .clk_i (clk_i), .d_i (inhibit_i), .q_o (inh_s)
  );

  dcnt_edge u_edge (
    .clk_i    (clk_i),
    .cclk_s_i (cclk_s),
    .inh_s_i  (inh_s),
    .adv_o    (adv)
  );

  dcnt_ring #(.RING_W(RING_W)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .adv_i   (adv),
    .state_o (state),
    .legal_o (legal)
  );

  dcnt_decode #(.RING_W(RING_W)) u_dec (
    .state_i (state),
    .dec_o   (dec_o),
    .carry_o (carry_o)
  );
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker #(
  parameter int RING_W = dcnt_pkg::RING_W_DEF,
  localparam int COUNT_N = 2 * RING_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               adv_i,
  input logic               legal_i,
  input logic [RING_W-1:0]  state_i,
  input logic [COUNT_N-1:0] dec_i,
  input logic               carry_i
);
  AST_STEP_ROTATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && legal_i |=> dec_i == {$past(dec_i[COUNT_N-2:0]), $past(dec_i[COUNT_N-1])}); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(state_i) || !legal_i)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (dec_i == COUNT_N'(1)) && carry_i); // R5

  AST_ONE_HOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_i |-> $onehot(dec_i)); // R6

  AST_CARRY_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_i |-> carry_i == (|dec_i[RING_W-1:0])); // R7

  AST_LOCKOUT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !legal_i |=> dec_i == COUNT_N'(1)); // R8
endmodule

bind johnson_decade_counter dcnt_checker #(.RING_W(RING_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_n),
  .adv_i   (adv),
  .legal_i (legal),
  .state_i (state),
  .dec_i   (dec_o),
  .carry_i (carry_o)
);

// File: tb/johnson_decade_counter_tb_top.sv
module johnson_decade_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 5;

  // Vector: {op[1:0], expected count[3:0]}
  // op 0: count-clock pulse, inhibit low (R2)
  // op 1: count-clock pulse inside an inhibit window (R3)
  // op 2: clock high, then inhibit falls (R4)
  localparam int NVEC = 16;
  localparam logic [5:0] VEC_TAB [NVEC] = '{
    {2'd0, 4'd1}, {2'd0, 4'd2}, {2'd1, 4'd2}, {2'd0, 4'd3},
    {2'd2, 4'd4}, {2'd0, 4'd5}, {2'd0, 4'd6}, {2'd1, 4'd6},
    {2'd0, 4'd7}, {2'd0, 4'd8}, {2'd2, 4'd9}, {2'd0, 4'd0},
    {2'd0, 4'd1}, {2'd1, 4'd1}, {2'd2, 4'd2}, {2'd0, 4'd3}
  };

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic cnt_clk = 1'b0;
  logic inhibit = 1'b0;
  logic [9:0] dec;
  logic carry;
  logic [4:0] frc_val = '0;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  johnson_decade_counter dut_i (
    .clk_i     (clk),
    .clr_i     (clr),
    .cnt_clk_i (cnt_clk),
    .inhibit_i (inhibit),
    .dec_o     (dec),
    .carry_o   (carry)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_count(input int exp, input string req);
    logic [9:0] exp_dec;
    exp_dec = 10'(1) << exp;
    n_checks++;
    if (dec !== exp_dec) begin
      n_fail++;
      $display("FAIL %s dec_o actual %b expected %b", req, dec, exp_dec);
    end
    n_checks++;
    if (carry !== (exp < 5)) begin
      n_fail++;
      $display("FAIL %s carry_o actual %b expected %b", req, carry, (exp < 5));
    end
  endtask

  task automatic do_pulse();
    cnt_clk = 1'b1; wait_n(HOLD);
    cnt_clk = 1'b0; wait_n(HOLD);
  endtask

  task automatic do_inh_pulse();
    inhibit = 1'b1; wait_n(HOLD);
    cnt_clk = 1'b1; wait_n(HOLD);
    cnt_clk = 1'b0; wait_n(HOLD);
    inhibit = 1'b0; wait_n(HOLD);
  endtask

  task automatic do_inh_fall();
    inhibit = 1'b1; wait_n(HOLD);
    cnt_clk = 1'b1; wait_n(HOLD);
    inhibit = 1'b0; wait_n(HOLD);
    cnt_clk = 1'b0; wait_n(HOLD);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    wait_n(4);
    check_count(0, "R5 count zero in clear");
    clr = 1'b0;
    wait_n(6);
    check_count(0, "R5 count zero after clear");

    // Table walk over the main stepping behaviour (R1, R2, R3, R4, R6, R7).
    for (int i = 0; i < NVEC; i++) begin
      case (VEC_TAB[i][5:4])
        2'd0:    do_pulse();
        2'd1:    do_inh_pulse();
        default: do_inh_fall();
      endcase
      check_count(int'(VEC_TAB[i][3:0]), "R1 R2 R3 R4 R6 R7 table");
    end

    // R2: falling count-clock edge alone does not step.
    cnt_clk = 1'b1; wait_n(HOLD);
    check_count(4, "R2 rising edge steps");
    cnt_clk = 1'b0; wait_n(HOLD);
    check_count(4, "R2 falling edge ignored");

    // R5: clear takes effect without a clock and overrides count edges.
    @(negedge clk);
    #1 clr = 1'b1;
    #1 check_count(0, "R5 asynchronous clear");
    do_pulse();
    check_count(0, "R5 edges ignored in clear");
    cnt_clk = 1'b1; wait_n(HOLD);
    clr = 1'b0; wait_n(HOLD + 2);
    check_count(0, "R5 no step on release with clock high");
    cnt_clk = 1'b0; wait_n(HOLD);

    // R7: carry rises on the 9 to 0 step.
    for (int s = 1; s <= 10; s++) begin
      do_pulse();
      check_count(s % 10, "R7 carry over a full decade");
    end

    // R8: every illegal ring pattern recovers to count 0 on the next step.
    for (int p = 0; p < 32; p++) begin
      logic [4:0] pat;
      int edges;
      pat = 5'(p);
      edges = 0;
      for (int b = 0; b < 4; b++) if (pat[b] != pat[b+1]) edges++;
      if (edges > 1) begin
        frc_val = pat;
        @(negedge clk);
        force dut_i.u_ring.state_q = frc_val;
        @(negedge clk);
        release dut_i.u_ring.state_q;
        wait_n(2);
        do_pulse();
        check_count(0, "R8 lock-out recovery");
      end
    end

    report();
  end
endmodule